// File: doc/BRIEF.md
# Clock Generator Power-Up Sequencer

This block brings a clock generator from power-off to normal operation. A digital supply-good bit starts the sequence. A settling delay follows. The block then waits for an active-low power-good input. When that input is seen low, the frequency-select straps are captured once. After a bounded enable delay, the clock outputs are switched on. Both delays are counted in pulses of a reference tick, so they are set by parameters and a testbench can shorten them.

Once the block reaches normal operation, further changes on the power-good input and the strap inputs have no effect. The only way out of normal operation is loss of supply. Loss of supply, in any state, returns the block to power-off, turns the outputs off and clears the captured straps.

Top module: `clkgen_pwrup_seq`

## Requirements
- R1: During reset, `state_o` is 0 (off), `clk_en_o` is 0 and `fsel_o` is 0.
- R2: In off (code 0), the clock after `supply_ok_i` is sampled high moves the state to settle (code 1).
- R3: In settle, the state moves to wait (code 2) on the clock that samples the SETTLE_TICKS-th high `tick_i` of that stay. Cycles with `tick_i` low do not count.
- R4: In wait, while `pwrgd_ni` stays high, the state remains wait, no ticks are counted and `fsel_o` keeps its cleared value.
- R5: The first clock in wait that samples `pwrgd_ni` low copies `fsel_i` into `fsel_o`. That value is then held until supply is lost.
- R6: After capture, the state moves to run (code 3) on the clock that samples the ENABLE_TICKS-th high `tick_i`. `clk_en_o` is 1 exactly while the state is run.
- R7: In run, `pwrgd_ni` and `fsel_i` have no effect: the state stays run and `fsel_o` does not change.
- R8: From any state, a clock that samples `supply_ok_i` low moves the state to off, drives `clk_en_o` to 0 and clears `fsel_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Reference tick, one-cycle pulse per delay unit |
| supply_ok_i | input | 1 | Analog supply reached its threshold |
| pwrgd_ni | input | 1 | Power-good, active low, synchronous to clk_i |
| fsel_i | input | SEL_W | Frequency-select strap inputs |
| state_o | output | 2 | Current state: 0 off, 1 settle, 2 wait, 3 run |
| fsel_o | output | SEL_W | Captured strap value |
| clk_en_o | output | 1 | Clock output enable |

## Verification
The assertions assume that `pwrgd_ni`, `supply_ok_i` and `tick_i` already change in the `clk_i` domain. They also assume both delay parameters are at least one tick. The bench drives every input on the falling clock edge. It keeps `tick_i` to single-cycle pulses on a fixed cadence, and it uses short delay parameters so that each state is reached many times. Supply is dropped both in settle and in run. Power-good is held low before the wait state begins, so that capture on the first wait cycle is also exercised.

// File: rtl/clkgen_pwrup_pkg.sv
package clkgen_pwrup_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_SETTLE = 2'd1,
    ST_WAIT   = 2'd2,
    ST_RUN    = 2'd3
  } seq_state_e;
endpackage

// File: rtl/seq_tick_timer.sv
module seq_tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && tick_i && (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= cnt_q + 1'b1;
  end

  // R3/R6: the count never reaches the active limit
  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < limit_i));
endmodule

// File: rtl/seq_strap_latch.sv
module seq_strap_latch #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         cap_i,
  input  logic [W-1:0] strap_i,
  output logic [W-1:0] strap_o,
  output logic         held_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_o <= '0;
      held_o  <= 1'b0;
    end else if (clr_i) begin
      strap_o <= '0;
      held_o  <= 1'b0;
    end else if (cap_i && !held_o) begin
      strap_o <= strap_i;
      held_o  <= 1'b1;
    end
  end

  a_r5_strap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_o && !clr_i) |=> ($stable(strap_o) && held_o));
endmodule

// File: rtl/clkgen_pwrup_seq.sv
module clkgen_pwrup_seq
  import clkgen_pwrup_pkg::*;
#(
  parameter int SEL_W        = 3,
  parameter int SETTLE_TICKS = 250,
  parameter int ENABLE_TICKS = 1800
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             supply_ok_i,
  input  logic             pwrgd_ni,
  input  logic [SEL_W-1:0] fsel_i,
  output logic [1:0]       state_o,
  output logic [SEL_W-1:0] fsel_o,
  output logic             clk_en_o
);
  localparam int MAX_TICKS = (SETTLE_TICKS > ENABLE_TICKS) ? SETTLE_TICKS : ENABLE_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] SETTLE_LIM = CNT_W'(SETTLE_TICKS);
  localparam logic [CNT_W-1:0] ENABLE_LIM = CNT_W'(ENABLE_TICKS);

  seq_state_e       state_q, state_d;
  logic             t_run, t_clr, t_done, held, cap, en_q;
  logic [CNT_W-1:0] t_limit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:    state_d = ST_SETTLE;
      ST_SETTLE: if (t_done) state_d = ST_WAIT;
      ST_WAIT:   if (held && t_done) state_d = ST_RUN;
      ST_RUN:    state_d = ST_RUN;
      default:   state_d = ST_OFF;
    endcase
    if (!supply_ok_i) state_d = ST_OFF;
  end

  assign t_run   = supply_ok_i && ((state_q == ST_SETTLE) || (state_q == ST_WAIT && held));
  assign t_clr   = !t_run || (state_d != state_q);
  assign t_limit = (state_q == ST_SETTLE) ? SETTLE_LIM : ENABLE_LIM;
  assign cap     = supply_ok_i && (state_q == ST_WAIT) && !pwrgd_ni;

  seq_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (t_clr),
    .run_i   (t_run),
    .tick_i  (tick_i),
    .limit_i (t_limit),
    .done_o  (t_done)
  );

  seq_strap_latch #(.W(SEL_W)) u_straps (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!supply_ok_i),
    .cap_i   (cap),
    .strap_i (fsel_i),
    .strap_o (fsel_o),
    .held_o  (held)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      en_q    <= (state_d == ST_RUN);
    end
  end

  assign state_o  = state_q;
  assign clk_en_o = en_q;

  a_r2_off_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && supply_ok_i) |=> (state_q == ST_SETTLE));
  a_r4_wait_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !held && pwrgd_ni && supply_ok_i) |=> (state_q == ST_WAIT && !held));
  a_r6_en_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o == (state_q == ST_RUN));
  a_r7_run_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && supply_ok_i) |=> (state_q == ST_RUN && $stable(fsel_o)));
  a_r8_supply_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (state_q == ST_OFF && !clk_en_o && fsel_o == '0));
endmodule

// File: tb/tb_clkgen_pwrup_seq.sv
module tb_clkgen_pwrup_seq;
  localparam int SEL_W = 3;
  localparam int SET_T = 5;
  localparam int EN_T  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, supply = 1'b0, pg_n = 1'b1;
  logic [SEL_W-1:0] fsel = '0;
  logic [1:0] state;
  logic [SEL_W-1:0] fsel_q;
  logic en;
  int n_run = 0, n_fail = 0, cyc = 0;

  int m_state = 0, m_cnt = 0, m_fsel = 0;
  bit m_held = 0;

  always #5 clk = ~clk;

  clkgen_pwrup_seq #(.SEL_W(SEL_W), .SETTLE_TICKS(SET_T), .ENABLE_TICKS(EN_T)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .supply_ok_i(supply),
    .pwrgd_ni(pg_n), .fsel_i(fsel), .state_o(state), .fsel_o(fsel_q), .clk_en_o(en));

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_held = 0; m_fsel = 0;
    end else if (!supply) begin
      m_state = 0; m_cnt = 0; m_held = 0; m_fsel = 0;
    end else begin
      case (m_state)
        0: begin m_state = 1; m_cnt = 0; end
        1: if (tick) begin
             m_cnt++;
             if (m_cnt == SET_T) begin m_state = 2; m_cnt = 0; end
           end
        2: if (!m_held) begin
             if (!pg_n) begin m_held = 1; m_fsel = int'(fsel); end
           end else if (tick) begin
             m_cnt++;
             if (m_cnt == EN_T) begin m_state = 3; m_cnt = 0; end
           end
        default: ;
      endcase
    end
  end

  // tick cadence and per-cycle comparison, both on the falling edge
  always @(negedge clk) begin
    cyc++;
    tick <= (cyc % 3 == 0);
    if (rst_n) begin
      n_run++;
      if (int'(state) != m_state || int'(fsel_q) != m_fsel || en != (m_state == 3)) begin
        n_fail++;
        $display("FAIL R3 model compare: state=%0d fsel=%0d en=%0d exp state=%0d fsel=%0d en=%0d",
                 state, fsel_q, en, m_state, m_fsel, (m_state == 3));
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_state(input int s);
    for (int g = 0; g < 500 && int'(state) != s; g++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 state", state, 0); chk("R1 en", en, 0); chk("R1 fsel", fsel_q, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 off without supply", state, 0);
    supply = 1'b1;
    @(negedge clk);
    chk("R2 settle entry", state, 1);
    wait_state(2);
    chk("R3 wait reached", state, 2);
    for (int i = 0; i < 20; i++) begin fsel = SEL_W'(i); @(negedge clk); end
    chk("R4 still waiting", state, 2); chk("R4 no capture", fsel_q, 0);
    fsel = 3'd5; pg_n = 1'b0;
    @(negedge clk);
    fsel = 3'd2; pg_n = 1'b1;
    @(negedge clk);
    chk("R5 captured", fsel_q, 5);
    chk("R6 not yet run", en, 0);
    wait_state(3);
    chk("R6 run", state, 3); chk("R6 enable", en, 1); chk("R5 held", fsel_q, 5);
    for (int i = 0; i < 30; i++) begin pg_n = i[0]; fsel = SEL_W'(i * 3); @(negedge clk); end
    chk("R7 run kept", state, 3); chk("R7 straps kept", fsel_q, 5);
    supply = 1'b0;
    @(negedge clk);
    chk("R8 off", state, 0); chk("R8 en off", en, 0); chk("R8 fsel cleared", fsel_q, 0);
    // second pass: drop supply in settle, then capture on first wait cycle
    supply = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 in settle", state, 1);
    supply = 1'b0;
    @(negedge clk);
    chk("R8 settle loss", state, 0);
    supply = 1'b1; pg_n = 1'b0; fsel = 3'd3;
    wait_state(2);
    @(negedge clk);
    fsel = 3'd6;
    chk("R5 early capture", fsel_q, 3);
    wait_state(3);
    chk("R6 second run", en, 1); chk("R5 second hold", fsel_q, 3);
    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule